// File: doc/BRIEF.md
# Shared Memory Host Access Guard

This block watches every access that a host makes through a shared memory window into an embedded core's memory. Each host read or write carries a translated core address. The guard flags the access as a violation when the address falls in a memory block whose read-protect input is set, or when it lands inside a reserved core address window given by an inclusive base and limit. Read violations and write violations latch into two separate sticky flags in a core-visible control/status register. The core clears each flag by writing 1 to it.

A third bit of the same register enables an error interrupt to the core. The interrupt is a registered level. The block also holds an 8-bit semaphore register for host/core handshaking. Its low nibble can be written only from the host side and its high nibble only from the core side. Both sides can read the full byte.

The core reaches its two registers through a one-bit register select: 0 picks the control/status register and 1 picks the semaphore register. The memory array, the host bus protocol and the address translation all sit outside the block.

Top module: `shm_host_guard`

## Requirements
- R1: A host read (hostReq=1, hostWrite=0) to a protected block or to the reserved window sets the read-error flag at control/status bit 0. The flag is visible after the clock edge that sampled the request. A permitted read leaves it unchanged.
- R2: A host write (hostReq=1, hostWrite=1) under the same violation conditions sets the write-error flag at control/status bit 1. A permitted write leaves it unchanged.
- R3: The block index is the top BLK_W bits of hostAddr, and readProt[index]=1 marks the block protected. An address A is reserved when rsvBase <= A <= rsvLimit, with both ends included.
- R4: A core write to the control/status register (coreAddr=0) clears each error flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: When a violation and a core clear hit the same flag on the same clock edge, the flag ends up set.
- R6: Control/status bit 2 is the interrupt enable, loaded by every core write to that register. coreIrq is a register. It equals the AND of the enable with the OR of both flags as they stood before the previous clock edge, so it rises or falls one cycle after the flags or the enable change.
- R7: After reset, the control/status register, both semaphore nibbles and coreIrq are all zero.
- R8: In the semaphore register, bits 3-0 are the host nibble and are written only through hostSemWe/hostSemWdata. Bits 7-4 are the core nibble and are written only by a core write with coreAddr=1, which ignores data bits 3-0. semView and coreRdata (coreAddr=1) both show the full byte.
- R9: Control/status bits 7-3 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Host access strobe, one cycle per access |
| hostWrite | input | 1 | Access direction: 1 for write, 0 for read |
| hostAddr | input | ADDR_W | Translated core address of the host access |
| readProt | input | 2**BLK_W | Read-protect bit for each memory block |
| rsvBase | input | ADDR_W | First address of the reserved window |
| rsvLimit | input | ADDR_W | Last address of the reserved window |
| hostSemWe | input | 1 | Host write strobe for the host semaphore nibble |
| hostSemWdata | input | SEM_W | New host semaphore nibble |
| semView | output | 2*SEM_W | Semaphore byte as seen by the host |
| coreWe | input | 1 | Core register write strobe |
| coreAddr | input | 1 | Core register select: 0 for control/status, 1 for semaphore |
| coreWdata | input | 2*SEM_W | Core write data |
| coreRdata | output | 2*SEM_W | Core read data for the selected register |
| coreIrq | output | 1 | Registered error interrupt to the core |

## Verification
The hardest situation to reach is a host violation and a core write-1-to-clear arriving on the same clock edge. Through normal traffic these two events only ever come one after the other. The bench raises the host strobe and the core write strobe together on the same falling edge, so the rising edge samples both at once. The interrupt's one-cycle lag is checked by sampling coreIrq on the cycle the flag changes and again on the cycle after it, both when the flag sets and when it clears.

// File: rtl/shm_guard_pkg.sv
package shm_guard_pkg;

  // Register select values on the core port.
  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_SEM  = 1'b1;

  // Strobes passed from the control decode into the datapath.
  typedef struct packed {
    logic setRd;      // host read violation
    logic setWr;      // host write violation
    logic clrRd;      // core write-1-to-clear of the read flag
    logic clrWr;      // core write-1-to-clear of the write flag
    logic ldEn;       // core writes the control/status register
    logic enVal;      // new interrupt enable value
    logic ldCoreSem;  // core writes its semaphore nibble
    logic ldHostSem;  // host writes its semaphore nibble
  } guardStrobe_t;

endpackage

// File: rtl/shm_guard_ctrl.sv
module shm_guard_ctrl
  import shm_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic                    hostReq,
  input  logic                    hostWrite,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic [(1<<BLK_W)-1:0]   readProt,
  input  logic [ADDR_W-1:0]       rsvBase,
  input  logic [ADDR_W-1:0]       rsvLimit,
  input  logic                    hostSemWe,
  input  logic                    coreWe,
  input  logic                    coreAddr,
  input  logic [DATA_W-1:0]       coreWdata,
  output guardStrobe_t            stb
);

  localparam int NUM_BLK = 1 << BLK_W;

  logic [BLK_W-1:0] blkIdx;
  logic             blkLocked;
  logic             inReserved;
  logic             violation;
  logic             ctrlWrite;
  logic             unusedWdata;

  assign blkIdx     = hostAddr[ADDR_W-1 -: BLK_W];
  assign blkLocked  = readProt[blkIdx];
  assign inReserved = (hostAddr >= rsvBase) && (hostAddr <= rsvLimit);
  assign violation  = hostReq && (blkLocked || inReserved);
  assign ctrlWrite  = coreWe && (coreAddr == SEL_CTRL);

  // Control/status bits above the enable carry no state.
  assign unusedWdata = ^coreWdata[DATA_W-1:3];

  always_comb begin
    stb           = '0;
    stb.setRd     = violation && !hostWrite;
    stb.setWr     = violation && hostWrite;
    stb.clrRd     = ctrlWrite && coreWdata[0];
    stb.clrWr     = ctrlWrite && coreWdata[1];
    stb.ldEn      = ctrlWrite;
    stb.enVal     = coreWdata[2];
    stb.ldCoreSem = coreWe && (coreAddr == SEL_SEM);
    stb.ldHostSem = hostSemWe;
  end

  // An access without the strobe must never produce a set (R1, R2).
  always_comb begin
    if (!hostReq) begin
      assert_no_set_idle_R1: assert (!stb.setRd && !stb.setWr);
    end
  end

  // The protect vector must cover every block index.
  if (NUM_BLK < 2) begin : g_blkCheck
    initial assert_blk_width_R3: assert (NUM_BLK >= 2);
  end

endmodule

// File: rtl/shm_guard_dp.sv
module shm_guard_dp
  import shm_guard_pkg::*;
#(
  parameter int SEM_W  = 4,
  parameter int DATA_W = 2 * SEM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobe_t      stb,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [SEM_W-1:0]  hostSemWdata,
  input  logic              coreAddr,
  output logic [DATA_W-1:0] coreRdata,
  output logic [DATA_W-1:0] semView,
  output logic              coreIrq
);

  localparam int PAD_W = DATA_W - 3;

  logic             rdErr, wrErr, irqEn, irqQ;
  logic [SEM_W-1:0] hostSem, coreSem;
  logic [DATA_W-1:0] ctrlView;
  logic             anyErr;

  assign anyErr = rdErr || wrErr;

  // Sticky error flags: a set on the same edge overrides a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdErr <= 1'b0;
      wrErr <= 1'b0;
    end else begin
      if (stb.setRd)      rdErr <= 1'b1;
      else if (stb.clrRd) rdErr <= 1'b0;
      if (stb.setWr)      wrErr <= 1'b1;
      else if (stb.clrWr) wrErr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      if (stb.ldEn) irqEn <= stb.enVal;
      irqQ <= irqEn && anyErr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostSem <= '0;
      coreSem <= '0;
    end else begin
      if (stb.ldHostSem) hostSem <= hostSemWdata;
      if (stb.ldCoreSem) coreSem <= coreWdata[DATA_W-1:SEM_W];
    end
  end

  assign ctrlView  = {{PAD_W{1'b0}}, irqEn, wrErr, rdErr};
  assign semView   = {coreSem, hostSem};
  assign coreRdata = (coreAddr == SEL_SEM) ? semView : ctrlView;
  assign coreIrq   = irqQ;

  assert_set_rd_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.setRd |=> rdErr);
  assert_no_spurious_rd_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!rdErr && !stb.setRd) |=> !rdErr);
  assert_set_wr_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setWr |=> wrErr);
  assert_sticky_rd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdErr && !stb.clrRd) |=> rdErr);
  assert_sticky_wr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrErr && !stb.clrWr) |=> wrErr);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setRd && stb.clrRd) |=> rdErr);
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn && anyErr) |=> coreIrq);
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEn || !anyErr) |=> !coreIrq);
  assert_core_sem_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldCoreSem |=> $stable(semView[DATA_W-1:SEM_W]));
  assert_host_sem_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ldHostSem |=> $stable(semView[SEM_W-1:0]));

  always_comb begin
    if (coreAddr == SEL_CTRL) begin
      assert_pad_zero_R9: assert (coreRdata[DATA_W-1:3] == '0);
    end
  end

endmodule

// File: rtl/shm_host_guard.sv
module shm_host_guard
  import shm_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3,
  parameter int SEM_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostReq,
  input  logic                  hostWrite,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [(1<<BLK_W)-1:0] readProt,
  input  logic [ADDR_W-1:0]     rsvBase,
  input  logic [ADDR_W-1:0]     rsvLimit,
  input  logic                  hostSemWe,
  input  logic [SEM_W-1:0]      hostSemWdata,
  output logic [2*SEM_W-1:0]    semView,
  input  logic                  coreWe,
  input  logic                  coreAddr,
  input  logic [2*SEM_W-1:0]    coreWdata,
  output logic [2*SEM_W-1:0]    coreRdata,
  output logic                  coreIrq
);

  localparam int DATA_W = 2 * SEM_W;

  guardStrobe_t stb;

  shm_guard_ctrl #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .hostReq   (hostReq),
    .hostWrite (hostWrite),
    .hostAddr  (hostAddr),
    .readProt  (readProt),
    .rsvBase   (rsvBase),
    .rsvLimit  (rsvLimit),
    .hostSemWe (hostSemWe),
    .coreWe    (coreWe),
    .coreAddr  (coreAddr),
    .coreWdata (coreWdata),
    .stb       (stb)
  );

  shm_guard_dp #(
    .SEM_W(SEM_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .coreWdata    (coreWdata),
    .hostSemWdata (hostSemWdata),
    .coreAddr     (coreAddr),
    .coreRdata    (coreRdata),
    .semView      (semView),
    .coreIrq      (coreIrq)
  );

endmodule

// File: tb/test_shm_host_guard.sv
module test_shm_host_guard;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostReq, hostWrite;
  logic [15:0] hostAddr;
  logic [7:0]  readProt;
  logic [15:0] rsvBase, rsvLimit;
  logic        hostSemWe;
  logic [3:0]  hostSemWdata;
  logic [7:0]  semView;
  logic        coreWe, coreAddr;
  logic [7:0]  coreWdata, coreRdata;
  logic        coreIrq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  shm_host_guard i_shm_host_guard (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .readProt(readProt), .rsvBase(rsvBase),
    .rsvLimit(rsvLimit), .hostSemWe(hostSemWe), .hostSemWdata(hostSemWdata),
    .semView(semView), .coreWe(coreWe), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .coreRdata(coreRdata), .coreIrq(coreIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic sel, output logic [7:0] val);
    coreAddr = sel;
    #1;
    val = coreRdata;
  endtask

  task automatic hostAccess(input logic wr, input logic [15:0] addr);
    hostReq = 1'b1; hostWrite = wr; hostAddr = addr;
    step();
    hostReq = 1'b0; hostWrite = 1'b0;
  endtask

  task automatic coreWrite(input logic sel, input logic [7:0] data);
    coreWe = 1'b1; coreAddr = sel; coreWdata = data;
    step();
    coreWe = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    readReg(1'b0, v); check("R7 ctrl reset", v, 8'h00);
    readReg(1'b1, v); check("R7 sem reset", v, 8'h00);
    check("R7 irq reset", {7'b0, coreIrq}, 8'h00);
  endtask

  task automatic t_legal();
    logic [7:0] v;
    hostAccess(1'b0, 16'h1000);
    hostAccess(1'b1, 16'h1000);
    readReg(1'b0, v); check("R1 R2 permitted access sets nothing", v, 8'h00);
  endtask

  task automatic t_readProt();
    logic [7:0] v;
    hostAccess(1'b0, 16'h4010);
    readReg(1'b0, v); check("R1 read to protected block", v, 8'h01);
    step();
    check("R6 irq stays low while disabled", {7'b0, coreIrq}, 8'h00);
    coreWrite(1'b0, 8'h01);
    readReg(1'b0, v); check("R4 write 1 clears read flag", v, 8'h00);
  endtask

  task automatic t_writeProt();
    logic [7:0] v;
    hostAccess(1'b1, 16'h5FFF);
    readReg(1'b0, v); check("R2 write to protected block", v, 8'h02);
    coreWrite(1'b0, 8'h00);
    readReg(1'b0, v); check("R4 write 0 keeps flag", v, 8'h02);
    coreWrite(1'b0, 8'h01);
    readReg(1'b0, v); check("R4 clear of other flag keeps write flag", v, 8'h02);
    coreWrite(1'b0, 8'h02);
    readReg(1'b0, v); check("R4 write 1 clears write flag", v, 8'h00);
  endtask

  task automatic t_range();
    logic [7:0] v;
    hostAccess(1'b0, 16'hE000);
    readReg(1'b0, v); check("R3 reserved base inclusive", v, 8'h01);
    coreWrite(1'b0, 8'h01);
    hostAccess(1'b1, 16'hE0FF);
    readReg(1'b0, v); check("R3 reserved limit inclusive", v, 8'h02);
    coreWrite(1'b0, 8'h02);
    hostAccess(1'b0, 16'hDFFF);
    hostAccess(1'b1, 16'hE100);
    readReg(1'b0, v); check("R3 just outside window", v, 8'h00);
    hostAccess(1'b0, 16'h3FFF);
    hostAccess(1'b0, 16'h6000);
    readReg(1'b0, v); check("R3 neighbours of protected block", v, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    coreWrite(1'b0, 8'h04);
    readReg(1'b0, v); check("R6 enable bit reads back", v, 8'h04);
    hostAccess(1'b0, 16'h4000);
    check("R6 irq lags flag by a cycle", {7'b0, coreIrq}, 8'h00);
    step();
    check("R6 irq asserted", {7'b0, coreIrq}, 8'h01);
    coreWrite(1'b0, 8'h05);
    check("R6 irq still high on clear edge", {7'b0, coreIrq}, 8'h01);
    step();
    check("R6 irq drops after clear", {7'b0, coreIrq}, 8'h00);
    hostAccess(1'b1, 16'h4000);
    step();
    check("R6 irq from write flag", {7'b0, coreIrq}, 8'h01);
    coreWrite(1'b0, 8'h00);
    step();
    check("R6 irq drops when disabled", {7'b0, coreIrq}, 8'h00);
    readReg(1'b0, v); check("R6 flag kept while disabled", v, 8'h02);
    coreWrite(1'b0, 8'h02);
  endtask

  task automatic t_setWins();
    logic [7:0] v;
    hostAccess(1'b0, 16'h4000);
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 16'h4004;
    coreWe = 1'b1; coreAddr = 1'b0; coreWdata = 8'h01;
    step();
    hostReq = 1'b0; coreWe = 1'b0;
    readReg(1'b0, v); check("R5 set beats clear", v, 8'h01);
    coreWrite(1'b0, 8'h01);
    readReg(1'b0, v); check("R5 later clear works", v, 8'h00);
  endtask

  task automatic t_highBits();
    logic [7:0] v;
    coreWrite(1'b0, 8'hF8);
    readReg(1'b0, v); check("R9 upper bits read zero", v, 8'h00);
  endtask

  task automatic t_sem();
    logic [7:0] v;
    hostSemWe = 1'b1; hostSemWdata = 4'hA;
    step();
    hostSemWe = 1'b0;
    check("R8 host nibble on host view", semView, 8'h0A);
    readReg(1'b1, v); check("R8 host nibble on core view", v, 8'h0A);
    coreWrite(1'b1, 8'h5F);
    readReg(1'b1, v); check("R8 core write ignores low nibble", v, 8'h5A);
    hostSemWe = 1'b1; hostSemWdata = 4'h3;
    step();
    hostSemWe = 1'b0;
    check("R8 host write keeps core nibble", semView, 8'h53);
    readReg(1'b0, v); check("R8 sem writes leave ctrl alone", v, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hostReq = 1'b0; hostWrite = 1'b0; hostAddr = '0;
    readProt = 8'b0000_0100; rsvBase = 16'hE000; rsvLimit = 16'hE0FF;
    hostSemWe = 1'b0; hostSemWdata = '0;
    coreWe = 1'b0; coreAddr = 1'b0; coreWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_legal();
    t_readProt();
    t_writeProt();
    t_range();
    t_irq();
    t_setWins();
    t_highBits();
    t_sem();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule